// File: doc/BRIEF.md
# Calendar Alarm Compare and Interrupt Unit

This unit watches a running calendar time held in BCD by counters outside the block. It holds two complete alarm settings, a primary alarm and a power-off alarm, each with six fields: seconds, minutes, hours, day, month and year. A field cannot be masked, so an alarm fires only when the whole time is equal to its setting. The comparison is done only on cycles when the outside counters report a seconds update. A single match therefore raises its sticky status flag once.

Each source has its own status flag, cleared by writing 1 to it, and its own enable bit. The sources are the per-second tick, the primary alarm and the power-off alarm. Two interrupt lines are built from the flags and the enables. A wake output follows the primary alarm flag when wake routing is on. The power-off alarm can also drive an active-high power-enable pin low when power-off control is armed. The pin then stays low until the next reset, so an external power controller can switch the system off. Software reaches the block through a simple word-addressed register port with combinational read data.

Top module: `cal_alarm_irq`

## Requirements
- R1: After reset, every alarm field, the status word, the enable word, the wake word and the power word read 0. `pwr_en_o` is 1 and `timer_irq_o`, `alarm_irq_o` and `wake_o` are 0.
- R2: The primary alarm fields sit at byte addresses 0x20, 0x24, 0x28, 0x2C, 0x30 and 0x34, and the power-off alarm fields at 0x80 to 0x94 with the same stride. Within each set the order is seconds, minutes, hours, day, month, year, and this order matches the field order packed in `time_i` (seconds in bits 7:0, year in bits 47:40). Each field stores bits 7:0 of the write data and reads back zero-extended.
- R3: Status bit 6 (address 0x44) is set in the cycle after a cycle in which `tick_i` is 1 and all six fields of `time_i` equal the primary alarm fields. If any single field differs, or `tick_i` is 0, the bit does not set.
- R4: Status bit 7 is set under the same rule against the power-off alarm fields.
- R5: Status bit 2 is set in the cycle after every cycle in which `tick_i` is 1.
- R6: Writing to 0x44 clears each status bit whose data bit is 1 and leaves the bits written with 0 unchanged. If a set and a clear of the same bit fall in the same cycle, the bit ends up set.
- R7: The enable word at 0x48 has bit 2 for the timer, bit 3 for the primary alarm and bit 4 for the power-off alarm. `timer_irq_o` = status[2] AND enable[2]. `alarm_irq_o` = (status[6] AND enable[3]) OR (status[7] AND enable[4]). Writing 0 to the enable word masks both lines and leaves the alarm fields unchanged.
- R8: Bit 1 of the wake word at 0x7C routes the primary alarm flag to `wake_o`, so `wake_o` = wake[1] AND status[6].
- R9: Bit 16 of the power word at 0x98 arms power-off control. When a power-off alarm match occurs on a tick while the bit is set, `pwr_en_o` goes to 0 in the next cycle and stays 0 until reset, whatever is written later. A match while the bit is clear leaves `pwr_en_o` at 1.
- R10: Any address outside the map reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse when the time counters advance a second |
| time_i | input | 48 | Current BCD time, six 8-bit fields, seconds lowest |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from `addr_i` |
| timer_irq_o | output | 1 | Per-second interrupt |
| alarm_irq_o | output | 1 | Alarm interrupt, either alarm set |
| wake_o | output | 1 | Wakeup request from the primary alarm |
| pwr_en_o | output | 1 | Power enable to external controller, 0 means off |

## Verification
The bench builds the unit with its default parameters: six 8-bit fields, alarm sets based at 0x20 and 0x80 with a stride of 4, and a 32-bit data word. With these values the power-arm bit at position 16 exists in the data word. The defaults also make every field address and every single-field near miss reachable by direct stimulus. Random ticks with exact, perturbed and unrelated times run against random clear, enable and wake writes. This covers the interplay of sticky flags, masking and the latched power-off state.

// File: rtl/alarm_unit_pkg.sv
package alarm_unit_pkg;
  localparam logic [7:0] STS_OFS  = 8'h44;
  localparam logic [7:0] IEN_OFS  = 8'h48;
  localparam logic [7:0] WAKE_OFS = 8'h7C;
  localparam logic [7:0] PWR_OFS  = 8'h98;

  localparam int unsigned STS_SEC_BIT  = 2;
  localparam int unsigned STS_ALM_BIT  = 6;
  localparam int unsigned STS_ALM2_BIT = 7;
  localparam int unsigned IEN_TMR_BIT  = 2;
  localparam int unsigned IEN_ALM_BIT  = 3;
  localparam int unsigned IEN_ALM2_BIT = 4;
  localparam int unsigned WAKE_BIT     = 1;
  localparam int unsigned PWR_ARM_BIT  = 16;

  typedef struct packed {
    logic alm2;
    logic alm;
    logic sec;
  } flags_t;
endpackage

// File: rtl/alarm_cmp_set.sv
module alarm_cmp_set #(
  parameter int unsigned FIELD_W    = 8,
  parameter int unsigned NUM_FIELDS = 6,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned BASE       = 32'h20,
  parameter int unsigned STRIDE     = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [FIELD_W-1:0]            wdata_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] now_i,
  output logic                          match_o,
  output logic                          sel_o,
  output logic [FIELD_W-1:0]            rdata_o
);
  logic [NUM_FIELDS-1:0] fsel;
  logic [NUM_FIELDS-1:0] feq;
  logic [FIELD_W-1:0]    fval [NUM_FIELDS];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    assign fsel[g] = (addr_i == ADDR_W'(BASE + g * STRIDE));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              fval[g] <= '0;
      else if (we_i && fsel[g]) fval[g] <= wdata_i;
    end
    assign feq[g] = (fval[g] == now_i[g*FIELD_W +: FIELD_W]);
  end

  // no wildcard: every field has to agree
  assign match_o = &feq;
  assign sel_o   = |fsel;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (fsel[i]) rdata_o |= fval[i];
  end
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_unit_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              match_a_i,
  input  logic              match_b_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output flags_t            sts_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              timer_irq_o,
  output logic              alarm_irq_o,
  output logic              wake_o,
  output logic              pwr_en_o
);
  flags_t sts_q, sts_d;
  flags_t ien_q;
  logic   wake_q, arm_q, off_q;
  logic   wr_sts, wr_ien, wr_wake, wr_pwr;

  assign wr_sts  = we_i && (addr_i == ADDR_W'(STS_OFS));
  assign wr_ien  = we_i && (addr_i == ADDR_W'(IEN_OFS));
  assign wr_wake = we_i && (addr_i == ADDR_W'(WAKE_OFS));
  assign wr_pwr  = we_i && (addr_i == ADDR_W'(PWR_OFS));

  // clear first, set last: a same-cycle event wins
  always_comb begin
    sts_d = sts_q;
    if (wr_sts) begin
      if (wdata_i[STS_SEC_BIT])  sts_d.sec  = 1'b0;
      if (wdata_i[STS_ALM_BIT])  sts_d.alm  = 1'b0;
      if (wdata_i[STS_ALM2_BIT]) sts_d.alm2 = 1'b0;
    end
    if (tick_i) begin
      sts_d.sec = 1'b1;
      if (match_a_i) sts_d.alm  = 1'b1;
      if (match_b_i) sts_d.alm2 = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q  <= '0;
      ien_q  <= '0;
      wake_q <= 1'b0;
      arm_q  <= 1'b0;
      off_q  <= 1'b0;
    end else begin
      sts_q <= sts_d;
      if (wr_ien) ien_q <= '{alm2: wdata_i[IEN_ALM2_BIT], alm: wdata_i[IEN_ALM_BIT],
                             sec: wdata_i[IEN_TMR_BIT]};
      if (wr_wake) wake_q <= wdata_i[WAKE_BIT];
      if (wr_pwr)  arm_q  <= wdata_i[PWR_ARM_BIT];
      if (tick_i && match_b_i && arm_q) off_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(STS_OFS): begin
        rdata_o[STS_SEC_BIT]  = sts_q.sec;
        rdata_o[STS_ALM_BIT]  = sts_q.alm;
        rdata_o[STS_ALM2_BIT] = sts_q.alm2;
      end
      ADDR_W'(IEN_OFS): begin
        rdata_o[IEN_TMR_BIT]  = ien_q.sec;
        rdata_o[IEN_ALM_BIT]  = ien_q.alm;
        rdata_o[IEN_ALM2_BIT] = ien_q.alm2;
      end
      ADDR_W'(WAKE_OFS): rdata_o[WAKE_BIT]    = wake_q;
      ADDR_W'(PWR_OFS):  rdata_o[PWR_ARM_BIT] = arm_q;
      default: ;
    endcase
  end

  assign sts_o       = sts_q;
  assign timer_irq_o = sts_q.sec & ien_q.sec;
  assign alarm_irq_o = (sts_q.alm & ien_q.alm) | (sts_q.alm2 & ien_q.alm2);
  assign wake_o      = sts_q.alm & wake_q;
  assign pwr_en_o    = ~off_q;
endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq
  import alarm_unit_pkg::*;
#(
  parameter int unsigned FIELD_W    = 8,
  parameter int unsigned NUM_FIELDS = 6,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ALM_BASE   = 32'h20,
  parameter int unsigned ALM2_BASE  = 32'h80,
  parameter int unsigned STRIDE     = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] time_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic                          timer_irq_o,
  output logic                          alarm_irq_o,
  output logic                          wake_o,
  output logic                          pwr_en_o
);
  localparam int unsigned NSETS = 2;
  localparam int unsigned SET_BASE [NSETS] = '{ALM_BASE, ALM2_BASE};

  logic [NSETS-1:0]   match;
  logic [NSETS-1:0]   sel;
  logic [FIELD_W-1:0] set_rd [NSETS];
  logic [DATA_W-1:0]  ctl_rd;
  flags_t             sts;

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    alarm_cmp_set #(
      .FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS), .ADDR_W(ADDR_W),
      .BASE(SET_BASE[g]), .STRIDE(STRIDE)
    ) i_set (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
      .wdata_i(wdata_i[FIELD_W-1:0]), .now_i(time_i),
      .match_o(match[g]), .sel_o(sel[g]), .rdata_o(set_rd[g])
    );
  end

  alarm_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .match_a_i(match[0]), .match_b_i(match[1]),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .sts_o(sts), .rdata_o(ctl_rd),
    .timer_irq_o(timer_irq_o), .alarm_irq_o(alarm_irq_o),
    .wake_o(wake_o), .pwr_en_o(pwr_en_o)
  );

  always_comb begin
    rdata_o = ctl_rd;
    for (int i = 0; i < NSETS; i++)
      if (sel[i]) rdata_o |= DATA_W'(set_rd[i]);
  end
endmodule

// File: rtl/cal_alarm_irq_chk.sv
module cal_alarm_irq_chk
  import alarm_unit_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   tick_i,
  input logic   match_a_i,
  input logic   match_b_i,
  input flags_t sts_i,
  input logic   alarm_irq_o,
  input logic   wake_o,
  input logic   pwr_en_o
);
  a_r3_set_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && match_a_i |=> sts_i.alm);
  a_r3_rise_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_i.alm) |-> $past(tick_i && match_a_i));
  a_r4_set_on_match2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && match_b_i |=> sts_i.alm2);
  a_r5_sec_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> sts_i.sec);
  a_r7_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_irq_o |-> (sts_i.alm || sts_i.alm2));
  a_r8_wake_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> sts_i.alm);
  a_r9_pwr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o |=> !pwr_en_o);
  a_r9_pwr_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_en_o) |-> $past(tick_i && match_b_i));
endmodule

bind cal_alarm_irq cal_alarm_irq_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
  .match_a_i(match[0]), .match_b_i(match[1]), .sts_i(sts),
  .alarm_irq_o(alarm_irq_o), .wake_o(wake_o), .pwr_en_o(pwr_en_o)
);

// File: tb/test_cal_alarm_irq.sv
module test_cal_alarm_irq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [47:0] time_i = '0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        timer_irq_o, alarm_irq_o, wake_o, pwr_en_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0]  am [2][6];
  logic [31:0] m_sts, m_ien, m_wake, m_pwr;
  logic        m_off;

  cal_alarm_irq i_cal_alarm_irq (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] pack_set(int s);
    logic [47:0] v;
    for (int k = 0; k < 6; k++) v[k*8 +: 8] = am[s][k];
    return v;
  endfunction

  function automatic logic [47:0] perturb(logic [47:0] v, int k, int b);
    v[k*8 + b] = ~v[k*8 + b];
    return v;
  endfunction

  function automatic logic exp_tmr();
    return m_sts[2] & m_ien[2];
  endfunction
  function automatic logic exp_alm();
    return (m_sts[6] & m_ien[3]) | (m_sts[7] & m_ien[4]);
  endfunction
  function automatic logic exp_wake();
    return m_wake[1] & m_sts[6];
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 6; k++) am[s][k] = '0;
    m_sts = '0; m_ien = '0; m_wake = '0; m_pwr = '0; m_off = 1'b0;
  endtask

  task automatic model_write(logic [7:0] a, logic [31:0] d);
    for (int k = 0; k < 6; k++) begin
      if (a == 8'h20 + 8'(4*k)) am[0][k] = d[7:0];
      if (a == 8'h80 + 8'(4*k)) am[1][k] = d[7:0];
    end
    case (a)
      8'h44: m_sts &= ~(d & 32'hC4);
      8'h48: m_ien = d & 32'h1C;
      8'h7C: m_wake = d & 32'h2;
      8'h98: m_pwr = d & 32'h1_0000;
      default: ;
    endcase
  endtask

  task automatic model_tick(logic [47:0] tv);
    m_sts[2] = 1'b1;
    if (tv == pack_set(0)) m_sts[6] = 1'b1;
    if (tv == pack_set(1)) begin
      m_sts[7] = 1'b1;
      if (m_pwr[16]) m_off = 1'b1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    tick_i = 1'b0; we_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic tick(logic [47:0] tv);
    @(negedge clk_i);
    time_i = tv; tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    model_tick(tv);
  endtask

  task automatic check_all(string req);
    logic [31:0] d;
    rd(8'h44, d);
    check({req, " status"}, d, m_sts);
    check({req, " timer_irq"}, 32'(timer_irq_o), 32'(exp_tmr()));
    check({req, " alarm_irq"}, 32'(alarm_irq_o), 32'(exp_alm()));
    check({req, " wake"}, 32'(wake_o), 32'(exp_wake()));
    check({req, " pwr_en"}, 32'(pwr_en_o), 32'(!m_off));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [47:0] tv;
    void'($urandom(32'd4242));
    model_reset();
    do_reset();

    // R1 reset state
    foreach (am[s, k]) begin
      rd(s == 0 ? 8'h20 + 8'(4*k) : 8'h80 + 8'(4*k), d);
      check("R1 alarm field", d, 32'h0);
    end
    rd(8'h48, d); check("R1 ien", d, 0);
    rd(8'h7C, d); check("R1 wake reg", d, 0);
    rd(8'h98, d); check("R1 pwr reg", d, 0);
    check_all("R1");

    // R2 map and readback
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 6; k++)
        wr((s == 0 ? 8'h20 : 8'h80) + 8'(4*k), 32'hABCD_0000 | 32'(8'h11 * (k + 1) + 8'(s)));
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 6; k++) begin
        rd((s == 0 ? 8'h20 : 8'h80) + 8'(4*k), d);
        check("R2 readback", d, 32'(am[s][k]));
      end

    // R10 unmapped
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, d); check("R10 unmapped read", d, 0);
    check_all("R10");

    // R3/R5 exact match
    tick(pack_set(0));
    check("R3 alarm flag", 32'(m_sts[6]), 1);
    check_all("R3 R5");
    wr(8'h44, 32'hC4);
    check_all("R6 clear all");

    // R3 single-field near miss
    for (int k = 0; k < 6; k++) begin
      tick(perturb(pack_set(0), k, k));
      check_all("R3 near miss");
      wr(8'h44, 32'hC4);
    end

    // R3 match without tick
    @(negedge clk_i); time_i = pack_set(0);
    repeat (4) @(negedge clk_i);
    check_all("R3 no tick");

    // R6 write zero keeps, W1C single bit
    tick(pack_set(0));
    wr(8'h44, 32'h0);
    check_all("R6 write zero");
    wr(8'h44, 32'h40);
    check_all("R6 clear alarm only");
    // R6 set beats clear in same cycle
    @(negedge clk_i);
    time_i = pack_set(0); tick_i = 1'b1;
    we_i = 1'b1; addr_i = 8'h44; wdata_i = 32'h44;
    @(negedge clk_i);
    tick_i = 1'b0; we_i = 1'b0;
    model_write(8'h44, 32'h44);
    model_tick(pack_set(0));
    check_all("R6 set wins");

    // R7 enables
    wr(8'h48, 32'h1C);
    check_all("R7 enabled");
    wr(8'h48, 32'h0);
    check_all("R7 masked");
    rd(8'h2C, d); check("R7 alarm kept", d, 32'(am[0][3]));

    // R8 wake
    wr(8'h7C, 32'h2);
    check_all("R8 wake on");
    wr(8'h44, 32'h40);
    check_all("R8 wake follows flag");

    // R4/R9 alarm2 without arm
    tick(pack_set(1));
    check("R4 alarm2 flag", 32'(m_sts[7]), 1);
    check_all("R9 unarmed");
    // R9 armed
    wr(8'h98, 32'h1_0000);
    rd(8'h98, d); check("R9 pwr reg", d, 32'h1_0000);
    tick(pack_set(1));
    check("R9 pwr low", 32'(pwr_en_o), 0);
    wr(8'h44, 32'hC4);
    wr(8'h98, 32'h0);
    repeat (3) tick(48'h0);
    check_all("R9 stays off");
    do_reset();
    check_all("R1 R9 reset restores");

    // random mix
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 6; k++)
        wr((s == 0 ? 8'h20 : 8'h80) + 8'(4*k), $urandom & 32'hFF);
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 8;
      case (op)
        0: tick({$urandom, $urandom} & 48'hFFFF_FFFF_FFFF);
        1: tick(pack_set(0));
        2: tick(perturb(pack_set(0), $urandom % 6, $urandom % 8));
        3: tick(($urandom % 2) ? pack_set(1) : perturb(pack_set(1), $urandom % 6, $urandom % 8));
        4: wr(8'h44, $urandom);
        5: wr(8'h48, $urandom);
        6: wr(($urandom % 2) ? 8'h7C : 8'h98, $urandom);
        default: wr((($urandom % 2) ? 8'h20 : 8'h80) + 8'(4 * ($urandom % 6)), $urandom);
      endcase
      check_all("R3 R4 R6 R7 R8 R9 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule